// File: doc/BRIEF.md
# Steerable Dual-Output Interrupt Controller

This block gathers a parameterised set of interrupt request lines (16 by default) and merges them onto two processor interrupt outputs, a low-priority output and a high-priority output. For each source, software chooses whether the incoming line is active-high or active-low, whether it is recognised as a level or as a rising edge, and which of the two outputs it drives. Software checks the high-priority output first and uses it for error-class sources, which are normally set to edge mode.

Enables are never rewritten as a whole word. One register address sets enable bits and another clears them, so separate drivers can change their own sources without a read-modify-write race. A status register shows each source's raw pending state whatever its enable. Software ANDs that value with the enable readback to decide what to service. The lowest four sources come from general-purpose pins, and each of them is also gated by its own bit in a pin input-enable register.

Request lines are asynchronous. Each passes through a two-flop synchroniser before its polarity is adjusted and edges are detected. Both outputs are registered.

Top module: `dual_irq_steer`

## Requirements
- R1: After reset every enable, polarity, edge, steering and pin input-enable bit reads 0, status reads 0 while all requests are low, and both outputs are 0.
- R2: A write to address 0 sets each enable bit whose write-data bit is 1 and leaves bits written as 0 unchanged. Reads at address 0 or 1 return the current enable mask.
- R3: A write to address 1 clears each enable bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R4: When a source's bit in the polarity register (address 2) is 1, that source's request is treated as active-low. When the bit is 0, the request is active-high.
- R5: When a source's bit in the edge register (address 3) is 0, its status bit (address 5) follows the adjusted request and drops when the request goes inactive.
- R6: When a source's edge bit is 1, its status bit latches on a rising edge of the adjusted request and stays set after the request goes away. A later write of 1 to that bit at address 1 clears the latch, together with the enable. A request that is held active does not set the latch again. A new edge in the same cycle as the clear keeps the bit set.
- R7: A source whose bit in the steering register (address 4) is 1 drives the high-priority output irq_hi_o. A source whose bit is 0 drives irq_lo_o.
- R8: Status reports pending sources that are not enabled. An output is 1 only while at least one source steered to it is both pending and enabled.
- R9: Sources 0 to 3 are recognised only while the matching bit of the pin input-enable register (address 6, low 4 bits) is 1. Otherwise their status stays 0.
- R10: An active level request that meets an enabled source shows on its output at the third rising clock edge after the input changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Asynchronous interrupt request lines |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | NUM_SRC | Write data, one bit per source |
| rdata_o | output | NUM_SRC | Read data of the addressed register (combinational) |
| irq_lo_o | output | 1 | Low-priority interrupt output |
| irq_hi_o | output | 1 | High-priority interrupt output |

## Verification
The assertions assume that the write strobe and address are stable around the clock edge and that the write strobe stays low during reset. The stimulus changes bus signals only on falling edges and holds the strobe low whenever reset is driven. The request inputs may be fully asynchronous, but the edge and latency checks assume that each request level is held for at least one full clock period. The bench changes requests only on falling edges and holds them for several cycles, so no pulse can fall between synchroniser samples.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_EN_SET = 3'd0,
        SEL_EN_CLR = 3'd1,
        SEL_POL    = 3'd2,
        SEL_EDGE   = 3'd3,
        SEL_STEER  = 3'd4,
        SEL_STATUS = 3'd5,
        SEL_PIN_IE = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pol;
        logic edge_sel;
        logic steer;
        logic pin_ie;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (reg_sel_e'(a))
                SEL_EN_SET: s.en_set   = 1'b1;
                SEL_EN_CLR: s.en_clr   = 1'b1;
                SEL_POL:    s.pol      = 1'b1;
                SEL_EDGE:   s.edge_sel = 1'b1;
                SEL_STEER:  s.steer    = 1'b1;
                SEL_PIN_IE: s.pin_ie   = 1'b1;
                default:    s          = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/dual_irq_sync.sv
module dual_irq_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/dual_irq_regs.sv
module dual_irq_regs
    import dual_irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_PIN = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  wr_strobe_t         strobe_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] polarity_o,
    output logic [NUM_SRC-1:0] edge_mode_o,
    output logic [NUM_SRC-1:0] steer_o,
    output logic [NUM_PIN-1:0] pin_ie_o,
    output logic [NUM_SRC-1:0] pend_clr_o
);
    logic [NUM_SRC-1:0] enable_q, polarity_q, edge_q, steer_q;
    logic [NUM_PIN-1:0] pin_ie_q;
    logic [NUM_SRC-1:0] set_mask, clr_mask;

    assign set_mask = strobe_i.en_set ? wdata_i : '0;
    assign clr_mask = strobe_i.en_clr ? wdata_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            enable_q   <= '0;
            polarity_q <= '0;
            edge_q     <= '0;
            steer_q    <= '0;
            pin_ie_q   <= '0;
        end else begin
            enable_q <= (enable_q | set_mask) & ~clr_mask;
            if (strobe_i.pol)      polarity_q <= wdata_i;
            if (strobe_i.edge_sel) edge_q     <= wdata_i;
            if (strobe_i.steer)    steer_q    <= wdata_i;
            if (strobe_i.pin_ie)   pin_ie_q   <= wdata_i[NUM_PIN-1:0];
        end
    end

    assign enable_o    = enable_q;
    assign polarity_o  = polarity_q;
    assign edge_mode_o = edge_q;
    assign steer_o     = steer_q;
    assign pin_ie_o    = pin_ie_q;
    assign pend_clr_o  = clr_mask;
endmodule

// File: rtl/dual_irq_detect.sv
module dual_irq_detect #(
    parameter int NUM_SRC = 16,
    parameter int NUM_PIN = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] req_sync_i,
    input  logic [NUM_SRC-1:0] polarity_i,
    input  logic [NUM_SRC-1:0] edge_mode_i,
    input  logic [NUM_PIN-1:0] pin_ie_i,
    input  logic [NUM_SRC-1:0] pend_clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] active_prev_q;
    logic [NUM_SRC-1:0] latch_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_PIN) begin : g_pin
            // pin-sourced lines are qualified by their input enable
            assign active[i] = (req_sync_i[i] ^ polarity_i[i]) & pin_ie_i[i];
        end else begin : g_plain
            assign active[i] = req_sync_i[i] ^ polarity_i[i];
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                active_prev_q[i] <= 1'b0;
                latch_q[i]       <= 1'b0;
            end else begin
                active_prev_q[i] <= active[i];
                // a fresh rising edge wins over a clear in the same cycle
                latch_q[i] <= (active[i] & ~active_prev_q[i]) | (latch_q[i] & ~pend_clr_i[i]);
            end
        end

        assign status_o[i] = edge_mode_i[i] ? latch_q[i] : active[i];
    end
endmodule

// File: rtl/dual_irq_steer.sv
module dual_irq_steer
    import dual_irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_PIN = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               irq_lo_o,
    output logic               irq_hi_o
);
    wr_strobe_t         strobe;
    logic [NUM_SRC-1:0] req_sync;
    logic [NUM_SRC-1:0] en_q, pol_q, edge_q, steer_q, pend_clr;
    logic [NUM_PIN-1:0] pin_ie_q;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] live;
    logic               irq_lo_q, irq_hi_q;

    assign strobe = decode_write(wr_en_i, addr_i);

    dual_irq_sync #(.WIDTH(NUM_SRC)) sync_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(req_i),
        .sync_o (req_sync)
    );

    dual_irq_regs #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) regs_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .strobe_i   (strobe),
        .wdata_i    (wdata_i),
        .enable_o   (en_q),
        .polarity_o (pol_q),
        .edge_mode_o(edge_q),
        .steer_o    (steer_q),
        .pin_ie_o   (pin_ie_q),
        .pend_clr_o (pend_clr)
    );

    dual_irq_detect #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) detect_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_sync_i (req_sync),
        .polarity_i (pol_q),
        .edge_mode_i(edge_q),
        .pin_ie_i   (pin_ie_q),
        .pend_clr_i (pend_clr),
        .status_o   (status)
    );

    assign live = status & en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
        end else begin
            irq_lo_q <= |(live & ~steer_q);
            irq_hi_q <= |(live & steer_q);
        end
    end

    assign irq_lo_o = irq_lo_q;
    assign irq_hi_o = irq_hi_q;

    always_comb begin
        rdata_o = '0;
        case (reg_sel_e'(addr_i))
            SEL_EN_SET, SEL_EN_CLR: rdata_o = en_q;
            SEL_POL:    rdata_o = pol_q;
            SEL_EDGE:   rdata_o = edge_q;
            SEL_STEER:  rdata_o = steer_q;
            SEL_STATUS: rdata_o = status;
            SEL_PIN_IE: rdata_o[NUM_PIN-1:0] = pin_ie_q;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_irq_checker.sv
module dual_irq_checker #(
    parameter int NUM_SRC = 16,
    parameter int NUM_PIN = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [2:0]         addr_i,
    input logic               wr_en_i,
    input logic [NUM_SRC-1:0] wdata_i,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] steer_q,
    input logic [NUM_SRC-1:0] edge_q,
    input logic [NUM_PIN-1:0] pin_ie_q,
    input logic [NUM_SRC-1:0] status,
    input logic               irq_lo_o,
    input logic               irq_hi_o
);
    AST_RESET_QUIET: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!irq_lo_o && !irq_hi_o && en_q == '0)); // R1

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(wr_en_i) && $past(addr_i) == 3'd0)
        |-> ((en_q & $past(wdata_i)) == $past(wdata_i))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(wr_en_i) && $past(addr_i) == 3'd1)
        |-> ((en_q & $past(wdata_i)) == '0)); // R3

    AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && !($past(wr_en_i) && ($past(addr_i) == 3'd0 || $past(addr_i) == 3'd1)))
        |-> $stable(en_q)); // R2

    AST_LO_ROUTE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> (irq_lo_o == $past(|(status & en_q & ~steer_q)))); // R7

    AST_HI_ROUTE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> (irq_hi_o == $past(|(status & en_q & steer_q)))); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(en_q) == '0) |-> (!irq_lo_o && !irq_hi_o)); // R8

    AST_PIN_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        (status[NUM_PIN-1:0] & ~pin_ie_q & ~edge_q[NUM_PIN-1:0]) == '0); // R9
endmodule

bind dual_irq_steer dual_irq_checker #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .en_q    (en_q),
    .steer_q (steer_q),
    .edge_q  (edge_q),
    .pin_ie_q(pin_ie_q),
    .status  (status),
    .irq_lo_o(irq_lo_o),
    .irq_hi_o(irq_hi_o)
);

// File: tb/dual_irq_steer_tb.sv
module dual_irq_steer_tb_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [2:0]   addr = '0;
    logic         we = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dual_irq_steer #(.NUM_SRC(N), .NUM_PIN(4)) dut_i (
        .clk_i(clk), .rst_i(rst), .req_i(req), .addr_i(addr),
        .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata),
        .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
    );

    // {request, expected status, expected low output, expected high output}
    // config: all enabled, steer 16'hFF00, polarity 16'h00F0, level, pins enabled
    localparam logic [33:0] VECS [6] = '{
        {16'h00F0, 16'h0000, 1'b0, 1'b0},
        {16'h0000, 16'h00F0, 1'b1, 1'b0},
        {16'h01F0, 16'h0100, 1'b0, 1'b1},
        {16'h80F1, 16'h8001, 1'b1, 1'b1},
        {16'h0F0F, 16'h0FFF, 1'b1, 1'b1},
        {16'hF0F0, 16'hF000, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        we = 1'b0; req = '0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        do_reset();

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            check($sformatf("R1 reg %0d after reset", a), v, '0);
        end
        check("R1 outputs after reset", {14'b0, irq_hi, irq_lo}, '0);

        // R2 / R3 set and clear without touching other bits
        wr(3'd0, 16'h00A5);
        wr(3'd0, 16'h0300);
        rd(3'd0, v); check("R2 set accumulates", v, 16'h03A5);
        wr(3'd1, 16'h0021);
        rd(3'd1, v); check("R3 clear selected bits", v, 16'h0384);
        wr(3'd1, 16'h0000);
        rd(3'd0, v); check("R3 zero clear no effect", v, 16'h0384);

        // table walk: R4 polarity, R5 level, R7 steering
        do_reset();
        wr(3'd0, 16'hFFFF);
        wr(3'd4, 16'hFF00);
        wr(3'd2, 16'h00F0);
        wr(3'd6, 16'h000F);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            req = VECS[i][33:18];
            settle();
            rd(3'd5, v);
            check($sformatf("R4 R5 status vec %0d", i), v, VECS[i][17:2]);
            check($sformatf("R7 outputs vec %0d", i), {14'b0, irq_hi, irq_lo}, {14'b0, VECS[i][0], VECS[i][1]});
        end

        // R10 latency on source 5
        do_reset();
        wr(3'd0, 16'h0020);
        @(negedge clk);
        req[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R10 not yet after two edges", {15'b0, irq_lo}, 16'h0);
        @(posedge clk);
        @(negedge clk);
        check("R10 asserted on third edge", {15'b0, irq_lo}, 16'h1);
        req[5] = 1'b0;
        settle();
        check("R5 drops with request", {15'b0, irq_lo}, 16'h0);

        // R8 pending shown but not enabled
        do_reset();
        @(negedge clk); req[9] = 1'b1;
        settle();
        rd(3'd5, v); check("R8 status without enable", v, 16'h0200);
        check("R8 output masked", {14'b0, irq_hi, irq_lo}, '0);

        // R6 edge latch on source 8 steered high
        do_reset();
        wr(3'd3, 16'h0100);
        wr(3'd4, 16'h0100);
        wr(3'd0, 16'h0100);
        @(negedge clk); req[8] = 1'b1;
        @(negedge clk); @(negedge clk); req[8] = 1'b0;
        settle();
        rd(3'd5, v); check("R6 latched after pulse", v, 16'h0100);
        check("R6 high output", {14'b0, irq_hi, irq_lo}, 16'h2);
        wr(3'd1, 16'h0100);
        wr(3'd0, 16'h0100);
        settle();
        rd(3'd5, v); check("R6 cleared by clear write", v, 16'h0000);
        check("R6 output after clear", {14'b0, irq_hi, irq_lo}, '0);
        @(negedge clk); req[8] = 1'b1;
        settle();
        wr(3'd1, 16'h0100);
        wr(3'd0, 16'h0100);
        settle();
        rd(3'd5, v); check("R6 held request no relatch", v, 16'h0000);

        // R9 pin input enable on source 2
        do_reset();
        wr(3'd0, 16'h0004);
        @(negedge clk); req[2] = 1'b1;
        settle();
        rd(3'd5, v); check("R9 pin gated off", v, 16'h0000);
        check("R9 output gated off", {15'b0, irq_lo}, 16'h0);
        wr(3'd6, 16'h0004);
        settle();
        rd(3'd5, v); check("R9 pin gated on", v, 16'h0004);
        check("R9 output gated on", {15'b0, irq_lo}, 16'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule